// File: doc/BRIEF.md
# Constant-Time Ladder Scalar Multiplier

This block computes a scalar multiple Q = k·P with the Montgomery ladder. It keeps two working registers and, for every scalar bit after the leading one, performs exactly one group addition and one group doubling. Both operations run on every bit. The bit value only steers which register receives the sum and which register is doubled. Because of this, the number of cycles and the order of operations do not depend on the scalar.

The group operations come from a small internal arithmetic unit, so the block needs nothing outside itself. In this build a "point" is an integer modulo the prime `MODULUS`. Group addition is modular addition and doubling is modular doubling, so the final value equals k·P mod `MODULUS`. To use the block, a host drives a scalar and a base value, pulses `start` while `busy` is low, and waits for the one-cycle `done` pulse. `result` then holds the product.

Top module: `ml_ladder`

## Requirements
- R1: While reset is asserted, and after it is released, `busy` and `done` are low and `result` is 0 until a start is accepted.
- R2: `start` is accepted in any cycle where `busy` is low. `busy` is high in the next cycle. `k_in` and `p_in` are captured at acceptance, so later changes to those inputs do not affect the run.
- R3: `start` asserted while `busy` is high is ignored. It neither begins a new run nor changes the result of the run in progress, and each accepted start produces exactly one `done`.
- R4: With `p_in` < `MODULUS`, `result` during the `done` cycle equals (k' · P) mod `MODULUS`. Here k' is `k_in` with bit `KEY_W-1` forced to 1, because the leading scalar bit is taken as 1 and used up by the initialisation (R1 ← P, R0 ← 2P).
- R5: `done` is high exactly 2·`KEY_W`−1 clock cycles after the edge that accepts `start`, whatever the scalar. All-zero lower bits and all-one lower bits take the same time.
- R6: `done` lasts exactly one cycle, and `busy` is low while `done` is high.
- R7: `result` is always below `MODULUS`, and it does not change in any cycle that follows a cycle with `busy` low.
- R8: A start asserted during the `done` cycle is accepted, so runs can follow each other with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Request to begin a multiplication; accepted when `busy` is low |
| k_in | input | KEY_W | Scalar; the top bit is treated as 1 |
| p_in | input | VAL_W | Base value, below `MODULUS` |
| busy | output | 1 | High while a multiplication is in progress |
| done | output | 1 | One-cycle pulse marking a valid `result` |
| result | output | VAL_W | Final ladder register (k'·P mod `MODULUS`) |

## Verification
The assertions assume that `p_in` is below `MODULUS` whenever a start is accepted. They also assume that no start arrives during the two cycles after reset release, while the internal reset is still held. The bench reduces every base value modulo `MODULUS` before driving it. It waits for the reset synchroniser to release before issuing the first start. It scrambles `k_in` and `p_in` only when their values cannot be captured.

// File: rtl/ml_pkg.sv
package ml_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_INIT  = 3'd1,
    ST_CALC  = 3'd2,
    ST_WRITE = 3'd3,
    ST_FIN   = 3'd4
  } ml_state_e;

  // datapath strobes issued by the sequencer
  typedef struct packed {
    logic load;   // R1 <- P, R0 <- 2P
    logic calc;   // latch sum and double of pre-iteration values
    logic wback;  // steer both results back at once
  } ml_ctl_t;

endpackage

// File: rtl/ml_rst_sync.sv
module ml_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/ml_modadd.sv
module ml_modadd #(
  parameter int VAL_W   = 16,
  parameter int MODULUS = 65521
) (
  input  logic [VAL_W-1:0] a,
  input  logic [VAL_W-1:0] b,
  output logic [VAL_W-1:0] s
);

  localparam logic [VAL_W:0] MOD_EXT = (VAL_W+1)'(MODULUS);

  logic [VAL_W:0] raw_sum;
  logic [VAL_W:0] red_sum;

  always_comb begin
    raw_sum = {1'b0, a} + {1'b0, b};
    red_sum = raw_sum - MOD_EXT;
    s = (raw_sum >= MOD_EXT) ? red_sum[VAL_W-1:0] : raw_sum[VAL_W-1:0];
  end

endmodule

// File: rtl/ml_ctrl.sv
module ml_ctrl
  import ml_pkg::*;
#(
  parameter int KEY_W = 16,
  localparam int IDX_W = (KEY_W > 2) ? $clog2(KEY_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             accept,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] idx,
  output ml_ctl_t          ctl
);

  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(KEY_W - 2);

  ml_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  // next-state logic: no branch depends on a scalar bit
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    case (state_q)
      ST_IDLE, ST_FIN: begin
        if (start) begin
          state_d = ST_INIT;
          idx_d   = IDX_TOP;
          idx_en  = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_INIT:  state_d = ST_CALC;
      ST_CALC:  state_d = ST_WRITE;
      ST_WRITE: begin
        if (idx_q == '0) begin
          state_d = ST_FIN;
        end else begin
          state_d = ST_CALC;
          idx_d   = idx_q - 1'b1;
          idx_en  = 1'b1;
        end
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en) begin
        idx_q <= idx_d;
      end
    end
  end

  always_comb begin
    busy      = (state_q == ST_INIT) || (state_q == ST_CALC) || (state_q == ST_WRITE);
    done      = (state_q == ST_FIN);
    accept    = start && !busy;
    idx       = idx_q;
    ctl.load  = (state_q == ST_INIT);
    ctl.calc  = (state_q == ST_CALC);
    ctl.wback = (state_q == ST_WRITE);
  end

endmodule

// File: rtl/ml_ladder_dp.sv
module ml_ladder_dp
  import ml_pkg::*;
#(
  parameter int KEY_W   = 16,
  parameter int VAL_W   = 16,
  parameter int MODULUS = 65521,
  localparam int IDX_W  = (KEY_W > 2) ? $clog2(KEY_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [KEY_W-1:0] k_in,
  input  logic [VAL_W-1:0] p_in,
  input  logic [IDX_W-1:0] idx,
  input  ml_ctl_t          ctl,
  output logic [VAL_W-1:0] r1_out
);

  logic [KEY_W-1:0] k_q;
  logic [VAL_W-1:0] p_q;
  logic [VAL_W-1:0] r0_q, r1_q, r0_d, r1_d;
  logic [VAL_W-1:0] t_sum_q, t_dbl_q;
  logic [VAL_W-1:0] sum_w, dbl_w, dbl_opnd;
  logic [VAL_W-1:0] r0_wb, r1_wb;
  logic             ki;
  logic             r_en;

  // operand and destination steering by the current scalar bit
  always_comb begin
    ki       = k_q[idx];
    dbl_opnd = ctl.load ? p_q : (ki ? r0_q : r1_q);
    r1_wb    = ki ? t_sum_q : t_dbl_q;
    r0_wb    = ki ? t_dbl_q : t_sum_q;
    r_en     = ctl.load | ctl.wback;
    r1_d     = r1_q;
    r0_d     = r0_q;
    if (ctl.load) begin
      r1_d = p_q;
      r0_d = dbl_w;
    end else if (ctl.wback) begin
      r1_d = r1_wb;
      r0_d = r0_wb;
    end
  end

  ml_modadd #(.VAL_W(VAL_W), .MODULUS(MODULUS)) u_add (
    .a (r0_q),
    .b (r1_q),
    .s (sum_w)
  );

  ml_modadd #(.VAL_W(VAL_W), .MODULUS(MODULUS)) u_dbl (
    .a (dbl_opnd),
    .b (dbl_opnd),
    .s (dbl_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q     <= '0;
      p_q     <= '0;
      r0_q    <= '0;
      r1_q    <= '0;
      t_sum_q <= '0;
      t_dbl_q <= '0;
    end else begin
      if (accept) begin
        k_q <= k_in;
        p_q <= p_in;
      end
      if (ctl.calc) begin
        t_sum_q <= sum_w;
        t_dbl_q <= dbl_w;
      end
      if (r_en) begin
        r0_q <= r0_d;
        r1_q <= r1_d;
      end
    end
  end

  assign r1_out = r1_q;

endmodule

// File: rtl/ml_ladder.sv
module ml_ladder
  import ml_pkg::*;
#(
  parameter int KEY_W   = 16,
  parameter int VAL_W   = 16,
  parameter int MODULUS = 65521,
  localparam int IDX_W  = (KEY_W > 2) ? $clog2(KEY_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [KEY_W-1:0] k_in,
  input  logic [VAL_W-1:0] p_in,
  output logic             busy,
  output logic             done,
  output logic [VAL_W-1:0] result
);

  logic             rst_sync_n;
  logic             accept;
  logic [IDX_W-1:0] idx;
  ml_ctl_t          ctl;

  ml_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ml_ctrl #(.KEY_W(KEY_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (start),
    .accept (accept),
    .busy   (busy),
    .done   (done),
    .idx    (idx),
    .ctl    (ctl)
  );

  ml_ladder_dp #(.KEY_W(KEY_W), .VAL_W(VAL_W), .MODULUS(MODULUS)) u_dp (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .accept (accept),
    .k_in   (k_in),
    .p_in   (p_in),
    .idx    (idx),
    .ctl    (ctl),
    .r1_out (result)
  );

endmodule

// File: rtl/ml_ladder_chk.sv
module ml_ladder_chk #(
  parameter int KEY_W   = 16,
  parameter int VAL_W   = 16,
  parameter int MODULUS = 65521
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [VAL_W-1:0] p_in,
  input logic             busy,
  input logic             done,
  input logic [VAL_W-1:0] result
);

  localparam int LAT   = 2 * KEY_W - 1;
  localparam int LAT_W = $clog2(2 * KEY_W) + 1;
  localparam logic [VAL_W:0] MOD_EXT = (VAL_W+1)'(MODULUS);

  logic [LAT_W-1:0] lat_q;

  // cycles elapsed since the accepting edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (start && !busy) begin
      lat_q <= '0;
    end else if (busy) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  a_r4_base_range: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |-> ({1'b0, p_in} < MOD_EXT));

  a_r5_const_time: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == LAT_W'(LAT)));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(result));

  a_r7_result_range: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, result} < MOD_EXT));

endmodule

bind ml_ladder ml_ladder_chk #(.KEY_W(KEY_W), .VAL_W(VAL_W), .MODULUS(MODULUS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .p_in   (p_in),
  .busy   (busy),
  .done   (done),
  .result (result)
);

// File: tb/ml_ladder_tb_top.sv
`timescale 1ns/1ps
module ml_ladder_tb_top;

  localparam int KEY_W   = 16;
  localparam int VAL_W   = 16;
  localparam int MODULUS = 65521;
  localparam int LAT     = 2 * KEY_W - 1;

  typedef struct {
    logic [KEY_W-1:0] k;
    logic [VAL_W-1:0] p;
    logic [VAL_W-1:0] exp;
    longint           acc;
  } item_t;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [KEY_W-1:0] k_in;
  logic [VAL_W-1:0] p_in;
  logic             busy;
  logic             done;
  logic [VAL_W-1:0] result;

  item_t  exp_q[$];
  longint cyc = 0;
  int     tests = 0;
  int     fails = 0;
  int     pushed = 0;
  int     dones = 0;
  bit     prev_done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ml_ladder #(.KEY_W(KEY_W), .VAL_W(VAL_W), .MODULUS(MODULUS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .k_in(k_in), .p_in(p_in),
    .busy(busy), .done(done), .result(result)
  );

  function automatic logic [VAL_W-1:0] ref_mul(logic [KEY_W-1:0] k, logic [VAL_W-1:0] p);
    longint ke;
    ke = longint'(k) | (longint'(1) << (KEY_W - 1));
    return VAL_W'((ke * longint'(p)) % MODULUS);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: waits for an idle slot, pushes the expectation, pulses start
  task automatic drive(logic [KEY_W-1:0] k, logic [VAL_W-1:0] p);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1;
    k_in  = k;
    p_in  = p;
    it.k = k; it.p = p; it.exp = ref_mul(k, p); it.acc = cyc + 1;
    exp_q.push_back(it);
    pushed++;
    @(negedge clk);
    start = 1'b0;
    k_in  = KEY_W'($urandom);   // R2: must not reach the running job
    p_in  = VAL_W'($urandom);
  endtask

  // R3: start pulses with junk operands while a run is in progress
  task automatic poke_busy();
    repeat (3) @(negedge clk);
    start = 1'b1;
    k_in  = KEY_W'($urandom);
    p_in  = VAL_W'($urandom % MODULUS);
    repeat (2) @(negedge clk);
    start = 1'b0;
  endtask

  // monitor: pops and compares at each done
  initial begin
    forever begin
      @(negedge clk);
      if (prev_done && done)
        check(1'b0, "R6", "done longer than one cycle", 1, 0);
      if (done) begin
        item_t it;
        dones++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "done with no accepted start", dones, pushed);
        end else begin
          it = exp_q.pop_front();
          check(result == it.exp, "R4", "result", result, it.exp);
          check((cyc - it.acc) == LAT, "R5", "latency", cyc - it.acc, LAT);
          check(!busy, "R6", "busy during done", busy, 0);
        end
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [VAL_W-1:0] held;
    rst_n = 1'b0;
    start = 1'b0;
    k_in  = '0;
    p_in  = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && result == 0, "R1", "state in reset", {busy, done, result}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && result == 0, "R1", "state after release", {busy, done, result}, 0);

    // R5: equal time for all-zero and all-one lower bits
    drive(16'h8000, 16'd12345);
    drive(16'hFFFF, 16'd12345);
    drive(16'h8000, VAL_W'(MODULUS - 1));
    drive(16'hFFFF, VAL_W'(MODULUS - 1));
    drive(16'hA5C3, 16'd0);
    // R4: top bit clear is treated as set
    drive(16'h0000, 16'd777);
    drive(16'h1234, 16'd999);
    // R3: ignored starts during a run
    drive(16'hC0DE, 16'd4321);
    poke_busy();
    // R8: back-to-back runs through the random loop
    for (int i = 0; i < 40; i++) begin
      drive(KEY_W'($urandom), VAL_W'($urandom % MODULUS));
    end

    for (int w = 0; w < 200 && exp_q.size() != 0; w++) @(negedge clk);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R3", "pending results", exp_q.size(), 0);
    check(dones == pushed, "R3", "done count", dones, pushed);

    // R7: result held while idle, even with inputs moving
    held = result;
    for (int j = 0; j < 8; j++) begin
      k_in = KEY_W'($urandom);
      p_in = VAL_W'($urandom % MODULUS);
      @(negedge clk);
    end
    check(result == held && !busy && !done, "R7", "idle hold", result, held);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule